// File: doc/BRIEF.md
# Burst DMA Address Sequencer

This block generates the destination address and tracks the remaining byte count for one DMA channel that moves data in fixed 16-byte bursts. Software loads a destination pointer, a byte count, a line length, a row stride and a mode word through a small register-write port. It then pulses a start input. If the settings are valid, the channel raises a burst request toward a bus master and presents the current address and remaining count. Each acknowledge consumes one burst.

Two addressing modes are offered. In linear mode every burst advances the pointer by 16 bytes. In two-dimensional mode the pointer steps by 16 bytes inside a line of programmed length. When the last burst of a line is acknowledged, the pointer jumps to the start of the current line plus the row stride. In both modes the channel finishes when the count reaches zero. It then gives a one-cycle done pulse and drops its arm bit, so a later start needs a fresh mode write.

Top module: `burst_dma_addr_seq`

## Requirements
- R1: After reset, burst_req, done and err are 0, and burst_addr and bytes_left are 0.
- R2: A start pulse is accepted only when all of the following hold: the arm bit (mode bit 0) is 1; the pointer is a multiple of 16; the count is a nonzero multiple of 16; and, in two-dimensional mode (mode bit 1 = 1), the line length is a nonzero multiple of 16. An accepted start raises burst_req on the next cycle. A refused start leaves burst_req at 0 and sets err.
- R3: burst_req stays high until burst_ack is seen. While no acknowledge arrives, burst_addr and bytes_left hold their values.
- R4: In linear mode each acknowledged burst adds 16 to burst_addr. In both modes each acknowledged burst subtracts 16 from bytes_left. The update happens on the acknowledge cycle only.
- R5: In two-dimensional mode an acknowledge inside a line adds 16. An acknowledge on the last burst of a line (offset + 16 = line length) sets burst_addr to that line's start address plus the row stride.
- R6: The acknowledge that brings bytes_left to 0 gives done = 1 for exactly one cycle, starting the next cycle, with burst_req low. It also clears the arm bit, so a following start with no new mode write is refused and sets err.
- R7: A register write made while burst_req is high is ignored and sets err.
- R8: A mode write (select 4) with any of bits 31..2 set is ignored and sets err. Register selects: 0 pointer, 1 count, 2 row stride, 3 line length, 4 mode.
- R9: err stays set until reset, including through later successful transfers.
- R10: If a write and an acknowledge fall in the same cycle, the acknowledge update takes effect, the write is dropped and err is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 pointer, 1 count, 2 stride, 3 line length, 4 mode) |
| wr_data | input | 32 | Write data |
| start | input | 1 | Start pulse |
| burst_ack | input | 1 | Burst acknowledge from the bus master |
| burst_req | output | 1 | Burst request, held until acknowledged |
| burst_addr | output | 32 | Current burst destination address |
| bytes_left | output | 32 | Remaining byte count |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky error flag |

## Verification
Two functions can fall in the same cycle: a register write and a burst acknowledge. The final acknowledge can also coincide with a write. To provoke this, the bench raises wr_en and burst_ack on the same drive edge while a transfer is running, once mid-transfer and once on the last burst. It then judges that the address and count moved by exactly one burst step, that the written pointer value never shows on burst_addr, that err becomes set, and that done still pulses once when the last burst is involved.

// File: rtl/bdas_pkg.sv
package bdas_pkg;
  localparam int BURST_BYTES = 16;

  typedef enum logic [2:0] {
    SEL_PTR    = 3'd0,
    SEL_CNT    = 3'd1,
    SEL_STRIDE = 3'd2,
    SEL_LINE   = 3'd3,
    SEL_MODE   = 3'd4
  } reg_sel_e;

  localparam int MODE_ARM_BIT   = 0;
  localparam int MODE_ILACE_BIT = 1;
  localparam int MODE_USED_BITS = 2;
endpackage

// File: rtl/bdas_cfg.sv
module bdas_cfg
  import bdas_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_arm,
  output logic [DW-1:0] stride,
  output logic [DW-1:0] line_len,
  output logic          arm,
  output logic          ilace
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride   <= '0;
      line_len <= '0;
      arm      <= 1'b0;
      ilace    <= 1'b0;
    end else begin
      if (wr_ok && wr_sel == SEL_STRIDE) stride <= wr_data;
      if (wr_ok && wr_sel == SEL_LINE) line_len <= wr_data;
      if (wr_ok && wr_sel == SEL_MODE) begin
        arm   <= wr_data[MODE_ARM_BIT];
        ilace <= wr_data[MODE_ILACE_BIT];
      end else if (clr_arm) begin
        arm <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bdas_ptr.sv
module bdas_ptr #(
  parameter int AW    = 32,
  parameter int BURST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          restart,
  input  logic          step,
  input  logic          ilace,
  input  logic [AW-1:0] line_len,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] addr,
  output logic          line_wrap
);
  localparam logic [AW-1:0] STEP = AW'(BURST);

  logic [AW-1:0] line_base;
  logic [AW-1:0] offset;

  function automatic logic f_at_line_end(input logic [AW-1:0] off,
                                         input logic [AW-1:0] len);
    return (off + STEP) == len;
  endfunction

  function automatic logic [AW-1:0] f_next_line(input logic [AW-1:0] base,
                                                input logic [AW-1:0] strd);
    return base + strd;
  endfunction

  assign line_wrap = ilace && f_at_line_end(offset, line_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      line_base <= '0;
      offset    <= '0;
    end else if (load) begin
      addr      <= load_val;
      line_base <= load_val;
      offset    <= '0;
    end else if (restart) begin
      line_base <= addr;
      offset    <= '0;
    end else if (step) begin
      if (line_wrap) begin
        addr      <= f_next_line(line_base, stride);
        line_base <= f_next_line(line_base, stride);
        offset    <= '0;
      end else begin
        addr   <= addr + STEP;
        offset <= offset + STEP;
      end
    end
  end
endmodule

// File: rtl/bdas_cnt.sv
module bdas_cnt #(
  parameter int CW    = 32,
  parameter int BURST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          is_last
);
  localparam logic [CW-1:0] STEP = CW'(BURST);

  assign is_last = (count == STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (step) count <= count - STEP;
  end
endmodule

// File: rtl/bdas_ctrl.sv
module bdas_ctrl
  import bdas_pkg::*;
#(
  parameter int DW    = 32,
  parameter int BURST = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          arm,
  input  logic          ilace,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] line_len,
  input  logic          cnt_last,
  output logic          active,
  output logic          done,
  output logic          err,
  output logic          start_accept,
  output logic          fire,
  output logic          fire_last,
  output logic          wr_ok
);
  localparam int LSB_BITS = $clog2(BURST);

  logic start_refuse;
  logic mode_bad;
  logic wr_reject;

  function automatic logic f_aligned(input logic [DW-1:0] v);
    return v[LSB_BITS-1:0] == '0;
  endfunction

  function automatic logic f_start_ok(input logic a, input logic il,
                                      input logic [DW-1:0] p,
                                      input logic [DW-1:0] c,
                                      input logic [DW-1:0] l);
    return a && f_aligned(p) && f_aligned(c) && (c != '0) &&
           (!il || (f_aligned(l) && (l != '0)));
  endfunction

  assign mode_bad     = (wr_sel == SEL_MODE) && (|wr_data[DW-1:MODE_USED_BITS]);
  assign wr_ok        = wr_en && !active && !mode_bad;
  assign wr_reject    = wr_en && (active || mode_bad);
  assign start_accept = start && !active && f_start_ok(arm, ilace, addr, count, line_len);
  assign start_refuse = start && !active && !f_start_ok(arm, ilace, addr, count, line_len);
  assign fire         = active && ack;
  assign fire_last    = fire && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (start_accept)   active <= 1'b1;
      else if (fire_last) active <= 1'b0;
      done <= fire_last;
      if (wr_reject || start_refuse) err <= 1'b1;
    end
  end
endmodule

// File: rtl/burst_dma_addr_seq.sv
module burst_dma_addr_seq
  import bdas_pkg::*;
#(
  parameter int DW    = 32,
  parameter int BURST = BURST_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  input  logic          burst_ack,
  output logic          burst_req,
  output logic [DW-1:0] burst_addr,
  output logic [DW-1:0] bytes_left,
  output logic          done,
  output logic          err
);
  logic          wr_ok;
  logic          start_accept;
  logic          fire;
  logic          fire_last;
  logic          line_wrap;
  logic          cnt_last;
  logic          arm;
  logic          ilace;
  logic          active;
  logic [DW-1:0] stride;
  logic [DW-1:0] line_len;
  logic          ptr_load;
  logic          cnt_load;

  assign ptr_load  = wr_ok && (wr_sel == SEL_PTR);
  assign cnt_load  = wr_ok && (wr_sel == SEL_CNT);
  assign burst_req = active;

  bdas_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_sel(wr_sel), .wr_data(wr_data),
    .clr_arm(fire_last), .stride(stride), .line_len(line_len), .arm(arm), .ilace(ilace)
  );

  bdas_ptr #(.AW(DW), .BURST(BURST)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(wr_data),
    .restart(start_accept), .step(fire), .ilace(ilace), .line_len(line_len),
    .stride(stride), .addr(burst_addr), .line_wrap(line_wrap)
  );

  bdas_cnt #(.CW(DW), .BURST(BURST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(wr_data),
    .step(fire), .count(bytes_left), .is_last(cnt_last)
  );

  bdas_ctrl #(.DW(DW), .BURST(BURST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ack(burst_ack), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .arm(arm), .ilace(ilace),
    .addr(burst_addr), .count(bytes_left), .line_len(line_len), .cnt_last(cnt_last),
    .active(active), .done(done), .err(err), .start_accept(start_accept),
    .fire(fire), .fire_last(fire_last), .wr_ok(wr_ok)
  );
endmodule

// File: rtl/bdas_checker.sv
module bdas_checker #(
  parameter int DW    = 32,
  parameter int BURST = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          burst_req,
  input logic          burst_ack,
  input logic [DW-1:0] burst_addr,
  input logic [DW-1:0] bytes_left,
  input logic          done,
  input logic          err,
  input logic          fire,
  input logic          fire_last,
  input logic          line_wrap,
  input logic          start_accept,
  input logic          ilace
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req && !burst_ack |=> burst_req && $stable(burst_addr) && $stable(bytes_left));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> bytes_left == $past(bytes_left) - DW'(BURST));

  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !ilace |=> burst_addr == $past(burst_addr) + DW'(BURST));

  p_inline_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && ilace && !line_wrap |=> burst_addr == $past(burst_addr) + DW'(BURST));

  p_req_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_req && !start_accept |=> !burst_req);

  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_last |=> done && !burst_req && bytes_left == '0);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && burst_req |=> err);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind burst_dma_addr_seq bdas_checker #(.DW(DW), .BURST(BURST)) u_bdas_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .burst_req(burst_req),
  .burst_ack(burst_ack), .burst_addr(burst_addr), .bytes_left(bytes_left),
  .done(done), .err(err), .fire(fire), .fire_last(fire_last),
  .line_wrap(line_wrap), .start_accept(start_accept), .ilace(ilace)
);

// File: tb/burst_dma_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_dma_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0;
  logic        burst_ack = 1'b0;
  logic        burst_req;
  logic [31:0] burst_addr;
  logic [31:0] bytes_left;
  logic        done;
  logic        err;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  burst_dma_addr_seq u_burst_dma_addr_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .burst_ack(burst_ack), .burst_req(burst_req),
    .burst_addr(burst_addr), .bytes_left(bytes_left), .done(done), .err(err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; start = 1'b0; burst_ack = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic ack1();
    burst_ack = 1'b1;
    @(negedge clk);
    burst_ack = 1'b0;
  endtask

  task automatic setup(input logic [31:0] p, input logic [31:0] c, input logic [31:0] s,
                       input logic [31:0] l, input logic [31:0] m);
    wr(3'd0, p); wr(3'd1, c); wr(3'd2, s); wr(3'd3, l); wr(3'd4, m);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req", 32'(burst_req), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 err", 32'(err), 32'd0);
    chk("R1 addr", burst_addr, 32'd0);
    chk("R1 count", bytes_left, 32'd0);
  endtask

  task automatic t_linear();
    do_reset();
    setup(32'h2000, 32'd64, 32'd0, 32'd0, 32'h1);
    kick();
    chk("R2 accepted req", 32'(burst_req), 32'd1);
    repeat (3) @(negedge clk);
    chk("R3 held req", 32'(burst_req), 32'd1);
    chk("R3 held addr", burst_addr, 32'h2000);
    chk("R3 held count", bytes_left, 32'd64);
    for (int i = 0; i < 4; i++) begin
      chk("R4 addr", burst_addr, 32'h2000 + 32'(i) * 16);
      chk("R4 count", bytes_left, 32'd64 - 32'(i) * 16);
      ack1();
    end
    chk("R6 done", 32'(done), 32'd1);
    chk("R6 req low", 32'(burst_req), 32'd0);
    chk("R6 count zero", bytes_left, 32'd0);
    @(negedge clk);
    chk("R6 done one cycle", 32'(done), 32'd0);
    chk("R6 no err yet", 32'(err), 32'd0);
    wr(3'd1, 32'd32);
    kick();
    chk("R6 rearm refused", 32'(burst_req), 32'd0);
    chk("R6 rearm err", 32'(err), 32'd1);
  endtask

  task automatic t_interlaced();
    logic [31:0] exp_a;
    do_reset();
    setup(32'h1000, 32'd96, 32'h100, 32'd32, 32'h3);
    kick();
    for (int i = 0; i < 6; i++) begin
      exp_a = 32'h1000 + 32'(i / 2) * 32'h100 + 32'(i % 2) * 16;
      chk("R5 addr", burst_addr, exp_a);
      ack1();
    end
    chk("R5 done", 32'(done), 32'd1);
    chk("R5 err clear", 32'(err), 32'd0);
  endtask

  task automatic t_refuse();
    do_reset();
    setup(32'h2008, 32'd32, 32'd0, 32'd0, 32'h1);
    kick();
    chk("R2 misaligned ptr req", 32'(burst_req), 32'd0);
    chk("R2 misaligned ptr err", 32'(err), 32'd1);
    do_reset();
    setup(32'h2000, 32'd24, 32'd0, 32'd0, 32'h1);
    kick();
    chk("R2 odd count req", 32'(burst_req), 32'd0);
    chk("R2 odd count err", 32'(err), 32'd1);
    do_reset();
    setup(32'h2000, 32'd0, 32'd0, 32'd0, 32'h1);
    kick();
    chk("R2 zero count", 32'(burst_req), 32'd0);
    do_reset();
    setup(32'h2000, 32'd32, 32'd0, 32'd0, 32'h0);
    kick();
    chk("R2 unarmed", 32'(burst_req), 32'd0);
    chk("R2 unarmed err", 32'(err), 32'd1);
    do_reset();
    setup(32'h2000, 32'd32, 32'h100, 32'd0, 32'h3);
    kick();
    chk("R2 zero line", 32'(burst_req), 32'd0);
  endtask

  task automatic t_busy_write();
    do_reset();
    setup(32'h3000, 32'd48, 32'd0, 32'd0, 32'h1);
    kick();
    wr(3'd0, 32'h0009_0000);
    wr(3'd1, 32'd16);
    chk("R7 addr kept", burst_addr, 32'h3000);
    chk("R7 count kept", bytes_left, 32'd48);
    chk("R7 err", 32'(err), 32'd1);
    ack1();
    chk("R7 step after", burst_addr, 32'h3010);
    ack1(); ack1();
    chk("R9 done", 32'(done), 32'd1);
    @(negedge clk);
    chk("R9 err still set", 32'(err), 32'd1);
  endtask

  task automatic t_mode_reserved();
    do_reset();
    setup(32'h4000, 32'd32, 32'd0, 32'd0, 32'h1);
    wr(3'd4, 32'h0000_0006);
    chk("R8 err", 32'(err), 32'd1);
    kick();
    chk("R8 old mode kept", 32'(burst_req), 32'd1);
    ack1();
    chk("R8 linear step", burst_addr, 32'h4010);
  endtask

  task automatic t_same_cycle();
    do_reset();
    setup(32'h5000, 32'd48, 32'd0, 32'd0, 32'h1);
    kick();
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0007_7770; burst_ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; burst_ack = 1'b0;
    chk("R10 addr", burst_addr, 32'h5010);
    chk("R10 count", bytes_left, 32'd32);
    chk("R10 err", 32'(err), 32'd1);
    ack1();
    wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'd160; burst_ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; burst_ack = 1'b0;
    chk("R10 last done", 32'(done), 32'd1);
    chk("R10 last count", bytes_left, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_linear();
    t_interlaced();
    t_refuse();
    t_busy_write();
    t_mode_reserved();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule